// File: doc/BRIEF.md
# Rotate and Wrap Mask Unit

This block is the rotate-and-mask stage of a 32-bit integer datapath. It takes a source word and rotates it left. It then merges the rotated word with a mask. The mask is built from a begin index and an end index, both counted in big-endian bit order. In AND mode the mask clears every bit outside the window. In insert mode the bits outside the window come from the existing destination word. When the begin index is past the end index, the window of ones wraps from the least significant end back to the most significant end.

The same rotator and mask generator also perform logical left shift, logical right shift and arithmetic right shift. The control logic turns a shift amount into a rotate amount plus a mask, and the arithmetic form adds sign fill. If the record bit is set, a 4-bit condition code for negative, positive or zero accompanies the result. Register-file access stays outside the block: operands arrive as words and the result leaves as a word.

Operations enter on a valid/ready handshake and results leave on another, with one register stage in between. An operation is accepted when `in_valid` and `in_ready` are both high at a clock edge. Its result appears on the next cycle. A result is held unchanged for as long as `out_valid` is high and `out_ready` is low, and no new operation is accepted during that time. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so one operation per cycle can stream through.

Top module: `rotmask_unit`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: Bit numbering is big-endian: index i is vector bit 31-i, so index 0 is the most significant bit. For op 0 or 1 with `mask_begin` <= `mask_end`, the mask has ones at every index from begin through end inclusive and zeros elsewhere. Equal begin and end give a single one.
- R3: For op 0 or 1 with `mask_begin` > `mask_end`, the mask has ones at indices from begin up to 31 and from 0 up to end, and zeros between them.
- R4: Op 0 (AND form) produces rotl(src, amount) AND mask.
- R5: Op 1 (insert form) produces (rotl(src, amount) AND mask) OR (dest AND NOT mask).
- R6: The amount source is selected by `amt_sel`. With `amt_sel`=0 the amount is `amt_imm`. With `amt_sel`=1, rotates use only `amt_reg[4:0]`, and the upper bits of `amt_reg` have no effect.
- R7: Ops 2, 3 and 4 are logical left shift, logical right shift and arithmetic right shift of src. With `amt_sel`=1 the shift amount is `amt_reg[5:0]`; with `amt_sel`=0 it is `amt_imm` zero-extended. Amounts from 32 to 63 give 0 for the logical shifts and 32 copies of src bit 31 for the arithmetic shift. The mask indices and dest have no effect on shifts.
- R8: With `record`=1, `out_cc` is 4'b1000 when result bit 31 is set, 4'b0100 when the result is nonzero with bit 31 clear, and 4'b0010 when the result is zero. With `record`=0, `out_cc` is 0.
- R9: Op codes 5, 6 and 7 behave exactly like op 0.
- R10: A result appears one cycle after acceptance. It stays unchanged while `out_valid`=1 and `out_ready`=0, and during that time `in_ready` is 0. With `out_ready`=1, operations stream back to back at one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| op_sel | input | 3 | 0 rotate-AND, 1 rotate-insert, 2 shift left, 3 logical shift right, 4 arithmetic shift right, 5-7 as 0 |
| amt_sel | input | 1 | 0 immediate amount, 1 register amount |
| amt_imm | input | 5 | Immediate amount |
| amt_reg | input | 32 | Register holding the amount |
| mask_begin | input | 5 | Mask begin index (big-endian) |
| mask_end | input | 5 | Mask end index (big-endian) |
| src_word | input | 32 | Word to rotate or shift |
| dest_word | input | 32 | Existing destination for insert form |
| record | input | 1 | Produce a condition code |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result taken downstream |
| out_result | output | 32 | Result word |
| out_cc | output | 4 | Condition code, or 0 without record |

## Verification
Two things can happen in the same cycle: a held result leaves on `out_ready`, and a new operation is accepted into the same register. The sweeps provoke this on every transfer by holding `in_valid` high continuously and presenting a new operand set in each cycle. Each result must match its own operation, not its neighbour's. A dedicated stall phase holds `out_ready` low while a second operation waits. It then judges that the first result stays stable and that the waiting operation arrives intact in the cycle after release.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  typedef enum logic [2:0] {
    OP_ROT_AND = 3'd0,
    OP_ROT_INS = 3'd1,
    OP_SHL     = 3'd2,
    OP_SHR     = 3'd3,
    OP_SAR     = 3'd4
  } rm_op_e;

  localparam logic [3:0] CC_NEG  = 4'b1000;
  localparam logic [3:0] CC_POS  = 4'b0100;
  localparam logic [3:0] CC_ZERO = 4'b0010;
  localparam logic [3:0] CC_NONE = 4'b0000;
endpackage

// File: rtl/rotmask_ctrl.sv
module rotmask_ctrl
  import rotmask_pkg::*;
#(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [2:0]     op_sel,
  input  logic           amt_sel,
  input  logic [SHW-1:0] amt_imm,
  input  logic [W-1:0]   amt_reg,
  input  logic [SHW-1:0] mb_in,
  input  logic [SHW-1:0] me_in,
  output logic [SHW-1:0] rot_amt,
  output logic [SHW-1:0] mb,
  output logic [SHW-1:0] me,
  output logic           kill,
  output logic           sar,
  output logic           ins
);
  logic [SHW:0]   n_full;
  logic [SHW-1:0] k;
  logic           big;

  always_comb begin
    n_full = amt_sel ? amt_reg[SHW:0] : {1'b0, amt_imm};
    k      = n_full[SHW-1:0];
    big    = n_full[SHW];
    rot_amt = k;
    mb   = mb_in;
    me   = me_in;
    kill = 1'b0;
    sar  = 1'b0;
    ins  = 1'b0;
    case (rm_op_e'(op_sel))
      OP_ROT_INS: ins = 1'b1;
      OP_SHL: begin
        mb   = '0;
        me   = SHW'(W - 1 - int'(k));
        kill = big;
      end
      OP_SHR, OP_SAR: begin
        rot_amt = SHW'(W - int'(k));
        mb   = k;
        me   = '1;
        kill = big;
        sar  = (rm_op_e'(op_sel) == OP_SAR);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [SHW-1:0] mb,
  input  logic [SHW-1:0] me,
  input  logic           kill,
  output logic [W-1:0]   mask
);
  logic wrap;
  assign wrap = (mb > me);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam logic [SHW-1:0] IDX = SHW'(i);
    logic ge_b, le_e;
    assign ge_b = (IDX >= mb);
    assign le_e = (IDX <= me);
    assign mask[W-1-i] = !kill && (wrap ? (ge_b || le_e) : (ge_b && le_e));
  end
endmodule

// File: rtl/rotmask_rotl.sv
module rotmask_rotl #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] amt,
  output logic [W-1:0]   dout
);
  logic [W-1:0] stage [0:SHW];
  assign stage[0] = din;

  for (genvar g = 0; g < SHW; g++) begin : g_stage
    localparam int S = 1 << g;
    assign stage[g+1] = amt[g] ? {stage[g][W-1-S:0], stage[g][W-1:W-S]} : stage[g];
  end

  assign dout = stage[SHW];
endmodule

// File: rtl/rotmask_ccgen.sv
module rotmask_ccgen
  import rotmask_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] value,
  input  logic         record,
  output logic [3:0]   cc
);
  always_comb begin
    if (!record)            cc = CC_NONE;
    else if (value[W-1])    cc = CC_NEG;
    else if (value != '0)   cc = CC_POS;
    else                    cc = CC_ZERO;
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int W   = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [2:0]     op_sel,
  input  logic           amt_sel,
  input  logic [SHW-1:0] amt_imm,
  input  logic [W-1:0]   amt_reg,
  input  logic [SHW-1:0] mask_begin,
  input  logic [SHW-1:0] mask_end,
  input  logic [W-1:0]   src_word,
  input  logic [W-1:0]   dest_word,
  input  logic           record,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_result,
  output logic [3:0]     out_cc
);
  logic [SHW-1:0] rot_amt, mb, me;
  logic           kill, sar, ins;
  logic [W-1:0]   mask, rotated, fill, merged;
  logic [3:0]     cc_next;
  logic           accept;

  rotmask_ctrl #(.W(W)) u_ctrl (
    .op_sel(op_sel), .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_reg(amt_reg),
    .mb_in(mask_begin), .me_in(mask_end),
    .rot_amt(rot_amt), .mb(mb), .me(me), .kill(kill), .sar(sar), .ins(ins)
  );

  rotmask_maskgen #(.W(W)) u_mask (
    .mb(mb), .me(me), .kill(kill), .mask(mask)
  );

  rotmask_rotl #(.W(W)) u_rot (
    .din(src_word), .amt(rot_amt), .dout(rotated)
  );

  assign fill   = sar ? ({W{src_word[W-1]}} & ~mask) : '0;
  assign merged = ins ? ((rotated & mask) | (dest_word & ~mask))
                      : ((rotated & mask) | fill);

  rotmask_ccgen #(.W(W)) u_cc (
    .value(merged), .record(record), .cc(cc_next)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_cc     <= '0;
    end else begin
      if (accept) begin
        out_valid  <= 1'b1;
        out_result <= merged;
        out_cc     <= cc_next;
      end else if (out_ready) begin
        out_valid  <= 1'b0;
      end
    end
  end
endmodule

module rotmask_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic [3:0]   out_cc
);
  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cc));
  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R10
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R8
  cc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cc) && !out_cc[0]);
  // R8
  cc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cc == 4'b0010 |-> out_result == '0);
  // R8
  cc_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cc == 4'b1000 |-> out_result[W-1]);
  // R8
  cc_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_cc == 4'b0100 |-> !out_result[W-1] && out_result != '0);
endmodule

bind rotmask_unit rotmask_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_cc(out_cc)
);

// File: tb/rotmask_unit_tb.sv
module rotmask_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op_sel = '0;
  logic        amt_sel = 1'b0;
  logic [4:0]  amt_imm = '0;
  logic [31:0] amt_reg = '0;
  logic [4:0]  mask_begin = '0;
  logic [4:0]  mask_end = '0;
  logic [31:0] src_word = '0;
  logic [31:0] dest_word = '0;
  logic        record = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_cc;

  int checks = 0;
  int fails = 0;
  bit pend = 0;
  logic [31:0] exp_r;
  logic [3:0]  exp_c;
  string       exp_tag;

  always #5 clk = ~clk;

  rotmask_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_sel(op_sel), .amt_sel(amt_sel), .amt_imm(amt_imm), .amt_reg(amt_reg),
    .mask_begin(mask_begin), .mask_end(mask_end), .src_word(src_word),
    .dest_word(dest_word), .record(record), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_cc(out_cc)
  );

  function automatic logic [31:0] emask(int mb, int me);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) begin
      if (mb <= me) m[31-i] = (i >= mb) && (i <= me);
      else          m[31-i] = (i >= mb) || (i <= me);
    end
    return m;
  endfunction

  function automatic logic [31:0] erotl(logic [31:0] s, int n);
    if (n == 0) return s;
    return (s << n) | (s >> (32 - n));
  endfunction

  function automatic logic [3:0] ecc(logic [31:0] r, logic rec);
    if (!rec) return 4'b0000;
    if (r[31]) return 4'b1000;
    if (r != 0) return 4'b0100;
    return 4'b0010;
  endfunction

  function automatic logic [31:0] ecalc(int op, logic asel, int imm, logic [31:0] areg,
                                        int mb, int me, logic [31:0] s, logic [31:0] d);
    int n;
    logic [31:0] m;
    n = asel ? int'(areg[5:0]) : imm;
    m = emask(mb, me);
    case (op)
      1: return (erotl(s, n % 32) & m) | (d & ~m);
      2: return (n >= 32) ? 32'h0 : (s << n);
      3: return (n >= 32) ? 32'h0 : (s >> n);
      4: return 32'($signed(s) >>> n);
      default: return erotl(s, n % 32) & m;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic check_out();
    check(out_valid === 1'b1, {exp_tag, " valid"}, 32'(out_valid), 32'h1);
    check(out_result === exp_r, exp_tag, out_result, exp_r);
    check(out_cc === exp_c, {exp_tag, " R8 cc"}, 32'(out_cc), 32'(exp_c));
  endtask

  task automatic issue(input int op, input logic asel, input int imm, input logic [31:0] areg,
                       input int mb, input int me, input logic [31:0] s, input logic [31:0] d,
                       input logic rec, input string tag);
    @(negedge clk);
    if (pend) check_out();
    op_sel = 3'(op); amt_sel = asel; amt_imm = 5'(imm); amt_reg = areg;
    mask_begin = 5'(mb); mask_end = 5'(me); src_word = s; dest_word = d; record = rec;
    in_valid = 1'b1;
    exp_r = ecalc(op, asel, imm, areg, mb, me, s, d);
    exp_c = ecc(exp_r, rec);
    exp_tag = tag;
    pend = 1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (pend) check_out();
    in_valid = 1'b0;
    pend = 0;
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog R10 actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    logic [31:0] a_r, b_r;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(out_valid === 1'b0, "R1 reset out_valid", 32'(out_valid), 32'h0);
    check(in_ready === 1'b1, "R1 reset in_ready", 32'(in_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R1 after reset out_valid", 32'(out_valid), 32'h0);

    // R2 R3 R4: AND form over every begin/end pair
    for (int mb = 0; mb < 32; mb++) begin
      for (int me = 0; me < 32; me++) begin
        s = 32'h8000_0001 ^ (32'(mb * 32 + me) * 32'h9E37_79B9);
        issue(0, 1'b0, (mb * 7 + me) % 32, 32'h0, mb, me, s, 32'hFFFF_FFFF, 1'(me),
              (mb > me) ? "R3 R4 wrap and" : "R2 R4 and");
      end
    end
    // R2 R3 R5: insert form over every begin/end pair
    for (int mb = 0; mb < 32; mb++) begin
      for (int me = 0; me < 32; me++) begin
        s = 32'h1234_5678 + 32'(mb * 977 + me * 131);
        d = ~s ^ 32'h0F0F_3C3C;
        issue(1, 1'b0, (mb + me * 3) % 32, 32'h0, mb, me, s, d, 1'(mb),
              (mb > me) ? "R3 R5 wrap insert" : "R2 R5 insert");
      end
    end
    // R6: register rotate amount, junk in upper bits
    for (int n = 0; n < 32; n++) begin
      issue(0, 1'b1, 31 - n, {27'h5A5_A5A5, 5'(n)}, 0, 31, 32'hC000_0035, 32'h0, 1'b1,
            "R6 reg rotate amount");
      issue(1, 1'b1, 0, {26'h3FF_FFFF, 1'b1, 5'(n)}, 4, 27, 32'h0000_F00D, 32'hAAAA_5555, 1'b0,
            "R6 reg rotate insert");
    end
    // R7: shifts with register amounts 0..63, mask and dest fields arbitrary
    for (int op = 2; op <= 4; op++) begin
      for (int n = 0; n < 64; n++) begin
        issue(op, 1'b1, 0, {26'h0, 6'(n)}, n % 32, (n * 5) % 32, 32'h9234_5671, 32'hDEAD_BEEF,
              1'b1, "R7 shift reg neg src");
        issue(op, 1'b1, 17, {26'h2AA_AAAA, 6'(n)}, 31, 0, 32'h4000_0F01, 32'hFFFF_FFFF,
              1'(n), "R7 shift reg pos src");
      end
      for (int n = 0; n < 32; n++)
        issue(op, 1'b0, n, 32'hFFFF_FFFF, 3, 9, 32'hF0F0_1234, 32'h0, 1'b1,
              "R7 shift immediate");
    end
    // R8: zero result and record off
    issue(0, 1'b0, 0, 32'h0, 0, 31, 32'h0, 32'hFFFF_FFFF, 1'b1, "R8 zero cc");
    issue(0, 1'b0, 0, 32'h0, 0, 31, 32'h7FFF_FFFF, 32'h0, 1'b1, "R8 positive cc");
    issue(0, 1'b0, 0, 32'h0, 0, 31, 32'h8000_0000, 32'h0, 1'b0, "R8 record off");
    // R9: codes 5..7 act as AND form
    for (int op = 5; op < 8; op++)
      for (int k = 0; k < 8; k++)
        issue(op, 1'b0, k * 4 + 1, 32'h0, k * 3, 29 - k * 2, 32'hA5C3_0F96 + 32'(k),
              32'hFFFF_FFFF, 1'b1, "R9 spare code");
    flush();

    // R10 back-pressure
    @(negedge clk);
    out_ready = 1'b0;
    op_sel = 3'd0; amt_sel = 1'b0; amt_imm = 5'd4; mask_begin = 5'd0; mask_end = 5'd31;
    src_word = 32'h1234_5678; record = 1'b1; in_valid = 1'b1;
    a_r = 32'h2345_6781;
    @(negedge clk);
    check(out_result === a_r, "R10 first result", out_result, a_r);
    check(in_ready === 1'b0, "R10 stalled in_ready", 32'(in_ready), 32'h0);
    amt_imm = 5'd8; src_word = 32'h0000_00FF;
    b_r = 32'h0000_FF00;
    @(negedge clk);
    check(out_result === a_r, "R10 held result", out_result, a_r);
    check(out_cc === 4'b0100, "R10 held cc", 32'(out_cc), 32'h4);
    check(in_ready === 1'b0, "R10 still stalled", 32'(in_ready), 32'h0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R10 second valid", 32'(out_valid), 32'h1);
    check(out_result === b_r, "R10 second result", out_result, b_r);
    @(negedge clk);
    check(out_valid === 1'b0, "R10 drained", 32'(out_valid), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule